// File: doc/BRIEF.md
# Pipelined Rotation-Based Complex Sinusoid Generator

This block turns a phase word and an unsigned amplitude into a quadrature pair (cosine and sine) scaled by that amplitude. The core is a chain of shift-and-add vector rotation stages. Each stage holds one register. A starting vector on the real axis is turned through the requested phase. The block takes a new phase and amplitude pair on every clock and returns one result per clock after a fixed delay. This suits a bank of oscillators that is time-multiplexed through one datapath, where the phase accumulator sits outside the block.

The amplitude is first converted into a mantissa and a shift count. A leading-one search sets the shift. The mantissa always enters the rotator in the same magnitude window, so rounding noise is a fixed fraction of the signal. At the output the rotated components are truncated and then shifted back by the shift count, which is delayed to match. Small amplitudes therefore keep the same relative precision as large ones.

Full-circle coverage comes from the top two phase bits. The remaining bits form a signed residual angle. When the top two bits differ, the starting vector is negated. The rotator's inherent gain of about 1.6468 is left in the result.

Top module: `cplx_rotor_osc`

## Requirements
- R1: With `in_valid` high in a cycle, the matching `out_valid` pulse and result appear exactly M+2 = 16 rising edges later. Back-to-back inputs give back-to-back results in the same order.
- R2: For an 18-bit unsigned phase P (a full turn is 2^18) and amplitude A, `out_cos` ≈ 1.6468·A·cos(2πP/2^18)·2^11 and `out_sin` ≈ 1.6468·A·sin(2πP/2^18)·2^11. This holds in all four quadrants, at the quadrant boundaries and at A = 65535, without overflow. The sign of each output equals the sign of the rotator component before denormalisation.
- R3: For A ≠ 0, the shift count is 15 minus the bit index of A's leading one. The normalised mantissa magnitude lies in [2^15, 2^16), which is 0.25 to 0.5 of the 18-bit full scale.
- R4: In every rotation stage, the magnitude of the residual angle never grows beyond the larger of its incoming magnitude and that stage's arctangent constant. After the last stage it is at most the last constant plus M.
- R5: The first rotation stage outputs a y component equal to plus or minus its x component, and x passes through unchanged.
- R6: An amplitude of zero yields zero on both outputs.
- R7: The output error stays within 8·2^(15−s) output units, where s is the shift count of R3. For A = 1 this bound is 8 units on a signal of about 3373 units.
- R8: While no result is delivered, `out_valid` is low and both outputs keep their last values, whatever the inputs do.
- R9: During reset, `out_valid` and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_phase` and `in_amp` this cycle |
| in_phase | input | 18 | Unsigned phase, full turn = 2^18 |
| in_amp | input | 16 | Unsigned amplitude |
| out_valid | output | 1 | Result valid pulse |
| out_cos | output | 29 | Signed in-phase component |
| out_sin | output | 29 | Signed quadrature component |

## Verification
Several behaviours are checked by the in-RTL properties on every accepted sample. These are the mantissa window after normalisation, forcing a zero amplitude to a zero vector, the mirror form of the first stage, the shrinking of the residual angle and its final bound, sign preservation through denormalisation, and holding the output between results. Only the directed scenarios can show the numerical accuracy: they compare each output with an independently computed trigonometric value. The same applies to the exact latency, ordering under streaming, quadrant boundaries, and precision at tiny amplitudes.

// File: rtl/cro_pkg.sv
package cro_pkg;

  // Arctangent of 2^-i expressed on a phase scale where pi equals 2^(w-1).
  function automatic longint atan_unit(input int i, input int w);
    real ang;
    ang = $atan(1.0 / (2.0 ** i));
    return longint'($rtoi(ang / 3.141592653589793 * (2.0 ** (w - 1)) + 0.5));
  endfunction

  function automatic longint absl(input longint v);
    return (v < 0) ? -v : v;
  endfunction

endpackage

// File: rtl/cro_normalize.sv
module cro_normalize #(
  parameter int W  = 18,
  parameter int AW = 16,
  parameter int SW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [W-1:0]        in_phase,
  input  logic [AW-1:0]       in_amp,
  output logic                v_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] e_o,
  output logic [SW-1:0]       sh_o
);
  localparam int LIFT = W - 2 - AW;

  int                  lead;
  logic [SW-1:0]       sh_n;
  logic signed [W-1:0] mag_n;
  logic signed [W-1:0] x_n;
  logic signed [W-1:0] e_n;
  logic                flip_n;

  always_comb begin
    lead = 0;
    for (int k = 0; k < AW; k++) begin
      if (in_amp[k]) lead = k;
    end
    sh_n   = (in_amp == '0) ? '0 : SW'(AW - 1 - lead);
    mag_n  = W'(in_amp) << (int'(sh_n) + LIFT);
    flip_n = in_phase[W-1] ^ in_phase[W-2];
    x_n    = flip_n ? -mag_n : mag_n;
    e_n    = {in_phase[W-2], in_phase[W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o  <= 1'b0;
      x_o  <= '0;
      e_o  <= '0;
      sh_o <= '0;
    end else begin
      v_o <= in_valid;
      if (in_valid) begin
        x_o  <= x_n;
        e_o  <= e_n;
        sh_o <= sh_n;
      end
    end
  end

  // R3: a nonzero amplitude lands in the quarter-to-half full-scale window
  p_mant_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_amp != '0) |=>
      (cro_pkg::absl(longint'(x_o)) >= (longint'(1) << (W - 3))) &&
      (cro_pkg::absl(longint'(x_o)) <  (longint'(1) << (W - 2))));

  // R6: a zero amplitude produces a zero start vector
  p_zero_amp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_amp == '0) |=> (x_o == '0));

endmodule

// File: rtl/cro_stage0.sv
module cro_stage0 #(
  parameter int W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                v_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] e_i,
  output logic                v_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] e_o
);
  localparam logic signed [W-1:0] DELTA = W'(cro_pkg::atan_unit(0, W));

  logic signed [W-1:0] y_n;
  logic signed [W-1:0] e_n;

  always_comb begin
    y_n = e_i[W-1] ? -x_i : x_i;
    e_n = e_i[W-1] ? (e_i + DELTA) : (e_i - DELTA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
      e_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        x_o <= x_i;
        y_o <= y_n;
        e_o <= e_n;
      end
    end
  end

  // R5: first stage mirrors x into y with a sign only
  p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |=> ((y_o == x_o) || (y_o == -x_o)) && (x_o == $past(x_i)));

endmodule

// File: rtl/cro_stage.sv
module cro_stage #(
  parameter int W = 18,
  parameter int I = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                v_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic signed [W-1:0] e_i,
  output logic                v_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] e_o
);
  localparam logic signed [W-1:0] DELTA = W'(cro_pkg::atan_unit(I, W));

  logic signed [W-1:0] xs, ys;
  logic signed [W-1:0] x_n, y_n, e_n;

  always_comb begin
    xs = x_i >>> I;
    ys = y_i >>> I;
    if (!e_i[W-1]) begin
      x_n = x_i - ys;
      y_n = y_i + xs;
      e_n = e_i - DELTA;
    end else begin
      x_n = x_i + ys;
      y_n = y_i - xs;
      e_n = e_i + DELTA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
      e_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        x_o <= x_n;
        y_o <= y_n;
        e_o <= e_n;
      end
    end
  end

  // R4: residual angle does not grow past max(incoming, this stage's constant)
  p_eps_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |=> cro_pkg::absl(longint'(e_o)) <=
      ((cro_pkg::absl(longint'($past(e_i))) > longint'(DELTA)) ?
        cro_pkg::absl(longint'($past(e_i))) : longint'(DELTA)));

endmodule

// File: rtl/cro_denorm.sv
module cro_denorm #(
  parameter int W    = 18,
  parameter int AW   = 16,
  parameter int DROP = 4,
  parameter int SW   = 4,
  parameter int OW   = W - DROP + AW - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [W-1:0]  x_i,
  input  logic signed [W-1:0]  y_i,
  input  logic [SW-1:0]        sh_i,
  output logic                 v_o,
  output logic signed [OW-1:0] cos_o,
  output logic signed [OW-1:0] sin_o
);
  logic signed [OW-1:0] cw, sw_, cos_n, sin_n;

  always_comb begin
    cw    = {x_i[W-1:DROP], {(AW-1){1'b0}}};
    sw_   = {y_i[W-1:DROP], {(AW-1){1'b0}}};
    cos_n = cw  >>> sh_i;
    sin_n = sw_ >>> sh_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        cos_o <= cos_n;
        sin_o <= sin_n;
      end
    end
  end

  // R2: truncation and denormalisation keep the component sign
  p_sign_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |=> (($past(x_i) < 0) == (cos_o < 0)) && (($past(y_i) < 0) == (sin_o < 0)));

  // R8: outputs hold and valid stays low between results
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !v_i |=> !v_o && $stable(cos_o) && $stable(sin_o));

endmodule

// File: rtl/cplx_rotor_osc.sv
module cplx_rotor_osc #(
  parameter int W    = 18,
  parameter int M    = 14,
  parameter int AW   = 16,
  parameter int DROP = 4,
  localparam int SW  = $clog2(AW),
  localparam int OW  = W - DROP + AW - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_phase,
  input  logic [AW-1:0]        in_amp,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_cos,
  output logic signed [OW-1:0] out_sin
);
  localparam longint DLAST = cro_pkg::atan_unit(M - 1, W);

  logic                vld [M+1];
  logic signed [W-1:0] xv  [M+1];
  logic signed [W-1:0] yv  [M+1];
  logic signed [W-1:0] ev  [M+1];
  logic [SW-1:0]       sh0;
  logic [SW-1:0]       sh_pipe [M];

  assign yv[0] = '0;

  cro_normalize #(.W(W), .AW(AW), .SW(SW)) u_norm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
    .in_amp(in_amp), .v_o(vld[0]), .x_o(xv[0]), .e_o(ev[0]), .sh_o(sh0)
  );

  for (genvar k = 0; k < M; k++) begin : g_rot
    if (k == 0) begin : g_first
      cro_stage0 #(.W(W)) u_st (
        .clk(clk), .rst_n(rst_n), .v_i(vld[0]), .x_i(xv[0]), .e_i(ev[0]),
        .v_o(vld[1]), .x_o(xv[1]), .y_o(yv[1]), .e_o(ev[1])
      );
    end else begin : g_rest
      cro_stage #(.W(W), .I(k)) u_st (
        .clk(clk), .rst_n(rst_n), .v_i(vld[k]), .x_i(xv[k]), .y_i(yv[k]),
        .e_i(ev[k]), .v_o(vld[k+1]), .x_o(xv[k+1]), .y_o(yv[k+1]), .e_o(ev[k+1])
      );
    end
  end

  // Shift count travels alongside its sample, one register per rotation stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < M; k++) sh_pipe[k] <= '0;
    end else begin
      if (vld[0]) sh_pipe[0] <= sh0;
      for (int k = 1; k < M; k++) begin
        if (vld[k]) sh_pipe[k] <= sh_pipe[k-1];
      end
    end
  end

  cro_denorm #(.W(W), .AW(AW), .DROP(DROP), .SW(SW), .OW(OW)) u_out (
    .clk(clk), .rst_n(rst_n), .v_i(vld[M]), .x_i(xv[M]), .y_i(yv[M]),
    .sh_i(sh_pipe[M-1]), .v_o(out_valid), .cos_o(out_cos), .sin_o(out_sin)
  );

  // R4: residual angle has converged after the last stage
  p_residual_small_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld[M] |-> cro_pkg::absl(longint'(ev[M])) <= DLAST + M);

endmodule

// File: tb/tb_cplx_rotor_osc.sv
module tb_cplx_rotor_osc;
  localparam int LAT = 16;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic [17:0]        in_phase;
  logic [15:0]        in_amp;
  logic               out_valid;
  logic signed [28:0] out_cos;
  logic signed [28:0] out_sin;

  int checks = 0;
  int errors = 0;
  real kg;

  cplx_rotor_osc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
    .in_amp(in_amp), .out_valid(out_valid), .out_cos(out_cos), .out_sin(out_sin)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int shift_of(input int a);
    int lead = 0;
    for (int k = 0; k < 16; k++) if (a[k]) lead = k;
    return (a == 0) ? 0 : 15 - lead;
  endfunction

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_near(input string tag, input longint act, input real exp, input real tol);
    real d;
    checks++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0.1f (tol %0.1f)", tag, act, exp, tol);
    end
  endtask

  task automatic chk_vec(input string tag, input int ph, input int a,
                         input longint c, input longint s);
    real th, tol;
    th  = 2.0 * 3.141592653589793 * real'(ph) / 262144.0;
    tol = 8.0 * (2.0 ** (15 - shift_of(a)));
    chk_near({tag, " cos"}, c, kg * real'(a) * $cos(th) * 2048.0, tol);
    chk_near({tag, " sin"}, s, kg * real'(a) * $sin(th) * 2048.0, tol);
  endtask

  task automatic shot(input int ph, input int a, output int lat,
                      output longint c, output longint s);
    @(negedge clk);
    in_valid = 1'b1;
    in_phase = 18'(ph);
    in_amp   = 16'(a);
    lat = 0;
    c = 0;
    s = 0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      in_valid = 1'b0;
      lat++;
      if (out_valid) begin
        c = out_cos;
        s = out_sin;
        break;
      end
    end
  endtask

  task automatic t_reset();
    chk_eq("R9 valid in reset", longint'(out_valid), 0);
    chk_eq("R9 cos in reset", out_cos, 0);
    chk_eq("R9 sin in reset", out_sin, 0);
  endtask

  task automatic t_latency();
    int lat;
    longint c, s;
    shot(5000, 12000, lat, c, s);
    chk_eq("R1 latency", lat, LAT);
    chk_vec("R1 value", 5000, 12000, c, s);
  endtask

  task automatic t_quadrants();
    int phs [10] = '{0, 9000, 65536, 80000, 131072, 150000, 196608, 250000, 262143, 30000};
    int lat;
    longint c, s;
    for (int i = 0; i < 10; i++) begin
      int a = (i == 9) ? 65535 : 20000;
      shot(phs[i], a, lat, c, s);
      chk_vec($sformatf("R2 R4 R5 phase %0d", phs[i]), phs[i], a, c, s);
    end
  endtask

  task automatic t_small();
    int phs [4] = '{40000, 120000, 200000, 65536};
    int amps [4] = '{1, 3, 77, 2};
    int lat;
    longint c, s;
    for (int i = 0; i < 4; i++) begin
      shot(phs[i], amps[i], lat, c, s);
      chk_vec($sformatf("R3 R7 amp %0d", amps[i]), phs[i], amps[i], c, s);
    end
  endtask

  task automatic t_zero();
    int lat;
    longint c, s;
    shot(12345, 0, lat, c, s);
    chk_eq("R6 cos zero amp", c, 0);
    chk_eq("R6 sin zero amp", s, 0);
  endtask

  task automatic t_stream();
    int phs [6] = '{1000, 70000, 140000, 210000, 33333, 99999};
    int amps [6] = '{500, 40000, 9, 1234, 65535, 300};
    for (int j = 0; j < 6 + LAT; j++) begin
      @(negedge clk);
      if (j >= LAT) begin
        chk_eq("R1 stream valid", longint'(out_valid), 1);
        chk_vec($sformatf("R1 stream item %0d", j - LAT), phs[j-LAT], amps[j-LAT],
                out_cos, out_sin);
      end
      if (j < 6) begin
        in_valid = 1'b1;
        in_phase = 18'(phs[j]);
        in_amp   = 16'(amps[j]);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk_eq("R1 stream ends", longint'(out_valid), 0);
  endtask

  task automatic t_hold();
    int lat;
    longint c, s;
    shot(77777, 30000, lat, c, s);
    in_phase = 18'd123;
    in_amp   = 16'd7;
    repeat (6) @(negedge clk);
    chk_eq("R8 valid low while idle", longint'(out_valid), 0);
    chk_eq("R8 cos held", out_cos, c);
    chk_eq("R8 sin held", out_sin, s);
  endtask

  initial begin
    kg = 1.0;
    for (int i = 0; i < 14; i++) kg = kg * $sqrt(1.0 + 1.0 / (4.0 ** i));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_phase = '0;
    in_amp   = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_latency();
    t_quadrants();
    t_small();
    t_zero();
    t_stream();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule